// File: doc/BRIEF.md
# Keyed Code-Page Table Walker

This block resolves translation misses from both the instruction-side and the data-side translation buffers by walking a three-level page table in memory, one word read at a time. A miss arrives as a virtual page number plus a flag saying which side it came from. The walker starts from a root table pointer, indexes each level with a field of the page number, and ends with either a refill (physical page number plus attribute bits) or a page-fault indication that software handles.

Encrypted code pages get one extra step. At the second level, an entry of the otherwise spare type does not name a table. It holds the byte address of a keyed entry, which the walker reads with no index arithmetic. A keyed entry is five words long and has no alignment beyond a word: a translation word followed by four key words. The 128-bit key goes back only when an instruction-side walk reaches such an entry. A data-side walk that lands on the same entry returns the translation alone, so data reads see the stored bytes unchanged.

Top module: `kpt_walker`

## Requirements
- R1: After reset the walker shows `req_ready`=1, `done_valid`=0 and `mem_rd_valid`=0.
- R2: The walker reads the first-level entry at `root_ptr`+4*VPN[19:12], the second-level entry at B1+4*VPN[11:6] and the third-level entry at B2+4*VPN[5:0]. Here B is an entry with its two low bits cleared. A final entry at the third level returns `done_ppn`=entry[31:12] and `done_attr`=entry[11:2], with `done_key_valid`=0 and `done_key`=0, for either side.
- R3: Entry bits [1:0] give the type: 0 invalid, 1 table pointer, 2 final, 3 keyed redirect. An invalid entry at any level ends the walk with `done_fault`=1, and no further read is issued.
- R4: A keyed redirect at the second level makes the next read go to that entry with its two low bits cleared, with no index added. The word read there is the translation word, and it must be of type final or the walk faults.
- R5: An instruction-side walk that reaches a keyed entry at address P reads the key words at P+4, P+8, P+12 and P+16, in that order, for seven reads in all. Key word k lands in `done_key`[32k+31:32k], and `done_key_valid`=1.
- R6: A data-side walk that reaches a keyed entry returns the translation only. It issues no key reads (three reads in all), and `done_key_valid`=0 and `done_key`=0, even right after a keyed instruction walk.
- R7: A keyed redirect at the first or the third level faults. So does a final entry at the first or the second level, and so does a table pointer at the third level.
- R8: Only one memory read is outstanding at a time. `mem_rd_valid` is a single-cycle pulse, and no new read is issued before `mem_rsp_valid` answers the last one.
- R9: Each accepted miss yields exactly one single-cycle `done_valid` pulse, with `done_is_instr` echoing the miss side. `req_ready` is low from acceptance until the walk ends. A fault returns `done_ppn`=0, `done_attr`=0 and `done_key_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation miss present |
| req_ready | output | 1 | Walker idle, miss accepted this cycle if valid |
| req_vpn | input | 20 | Virtual page number of the miss |
| req_is_instr | input | 1 | 1 for an instruction-side miss, 0 for data-side |
| root_ptr | input | 32 | Byte address of the first-level table |
| mem_rd_valid | output | 1 | One-cycle word read request |
| mem_rd_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned word |
| done_valid | output | 1 | Walk result valid for one cycle |
| done_fault | output | 1 | Walk ended in a page fault |
| done_is_instr | output | 1 | Side of the miss that produced this result |
| done_ppn | output | 20 | Physical page number |
| done_attr | output | 10 | Attribute bits of the translation word |
| done_key_valid | output | 1 | `done_key` carries a page key |
| done_key | output | 128 | Page key, word 0 in the low bits |

## Verification
The bench runs a keyed page on the instruction side and then on the data side. A walker that leaked the key to data walks, or kept a stale key from the earlier walk, would show a nonzero key or an extra read. It checks the address of every read in the keyed sequence, because a design that added an index to the redirect pointer, or that assumed the five-word entry was aligned, would read the wrong words. It places redirect, final and table-pointer entries at every level where they are illegal, and it also plants an invalid translation word behind a redirect. A walker that accepted any of these would return a refill where a fault was due. Memory latency varies between walks, so a walker that issued a read before the previous response arrived would be caught by the outstanding-read monitor.

// File: rtl/kpt_pkg.sv
package kpt_pkg;

  typedef enum logic [1:0] {
    ENT_INVALID = 2'd0,
    ENT_TABLE   = 2'd1,
    ENT_LEAF    = 2'd2,
    ENT_KEYED   = 2'd3
  } ent_kind_e;

  typedef enum logic [2:0] {
    PH_L1   = 3'd0,
    PH_L2   = 3'd1,
    PH_L3   = 3'd2,
    PH_XLAT = 3'd3,
    PH_KEY  = 3'd4
  } walk_phase_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } walk_state_e;

endpackage

// File: rtl/kpt_entry_decode.sv
module kpt_entry_decode
  import kpt_pkg::*;
#(
  parameter int AW      = 32,
  parameter int PG_BITS = 12
) (
  input  logic [AW-1:0]         word,
  output ent_kind_e             kind,
  output logic [AW-1:0]         ptr,
  output logic [AW-PG_BITS-1:0] ppn,
  output logic [PG_BITS-3:0]    attr
);

  function automatic logic [AW-1:0] word_align(input logic [AW-1:0] w);
    return {w[AW-1:2], 2'b00};
  endfunction

  assign kind = ent_kind_e'(word[1:0]);
  assign ptr  = word_align(word);
  assign ppn  = word[AW-1:PG_BITS];
  assign attr = word[PG_BITS-1:2];

endmodule

// File: rtl/kpt_key_collect.sv
module kpt_key_collect #(
  parameter int AW        = 32,
  parameter int KEY_WORDS = 4,
  localparam int KIW      = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1,
  localparam int KEY_W    = AW * KEY_WORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr,
  input  logic [KIW-1:0]   idx,
  input  logic [AW-1:0]    wdata,
  output logic [KEY_W-1:0] key
);

  for (genvar k = 0; k < KEY_WORDS; k++) begin : g_slot
    logic [AW-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          slot_q <= '0;
      else if (clr)                        slot_q <= '0;
      else if (wr && idx == KIW'(k))       slot_q <= wdata;
    end
    assign key[k*AW +: AW] = slot_q;
  end

  AST_KEY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (key == '0)); // R6

endmodule

// File: rtl/kpt_walk_ctrl.sv
module kpt_walk_ctrl
  import kpt_pkg::*;
#(
  parameter int AW        = 32,
  parameter int L1_BITS   = 8,
  parameter int L2_BITS   = 6,
  parameter int L3_BITS   = 6,
  parameter int KEY_WORDS = 4,
  localparam int PG_BITS  = AW - L1_BITS - L2_BITS - L3_BITS,
  localparam int VPN_W    = AW - PG_BITS,
  localparam int LO_W     = L2_BITS + L3_BITS,
  localparam int KIW      = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic               req_is_instr,
  input  logic [AW-1:0]      root_ptr,
  output logic               mem_rd_valid,
  output logic [AW-1:0]      mem_rd_addr,
  input  logic               mem_rsp_valid,
  input  ent_kind_e          ent_kind,
  input  logic [AW-1:0]      ent_ptr,
  input  logic [VPN_W-1:0]   ent_ppn,
  input  logic [PG_BITS-3:0] ent_attr,
  output logic               key_clr,
  output logic               key_wr,
  output logic [KIW-1:0]     key_idx,
  output logic               done_valid,
  output logic               done_fault,
  output logic               done_is_instr,
  output logic [VPN_W-1:0]   done_ppn,
  output logic [PG_BITS-3:0] done_attr,
  output logic               done_key_valid
);

  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] base,
                                              input logic [AW-1:0] idx);
    return base + (idx << 2);
  endfunction

  function automatic logic [AW-1:0] next_word(input logic [AW-1:0] a);
    return a + AW'(4);
  endfunction

  walk_state_e        state_q;
  walk_phase_e        phase_q;
  logic [LO_W-1:0]    vlo_q;
  logic               instr_q;
  logic [AW-1:0]      rd_addr_q;
  logic [KIW-1:0]     kidx_q;
  logic               fault_q;
  logic [VPN_W-1:0]   ppn_q;
  logic [PG_BITS-3:0] attr_q;
  logic               keyv_q;
  logic               outst_q;

  logic               accept;
  logic               rsp_take;
  logic [L2_BITS-1:0] idx2;
  logic [L3_BITS-1:0] idx3;

  assign req_ready    = (state_q == ST_IDLE);
  assign accept       = req_valid && req_ready;
  assign rsp_take     = (state_q == ST_WAIT) && mem_rsp_valid;
  assign idx2         = vlo_q[LO_W-1 -: L2_BITS];
  assign idx3         = vlo_q[L3_BITS-1:0];

  assign mem_rd_valid = (state_q == ST_ISSUE);
  assign mem_rd_addr  = rd_addr_q;

  assign key_clr      = accept;
  assign key_wr       = rsp_take && (phase_q == PH_KEY);
  assign key_idx      = kidx_q;

  assign done_valid     = (state_q == ST_DONE);
  assign done_fault     = fault_q;
  assign done_is_instr  = instr_q;
  assign done_ppn       = ppn_q;
  assign done_attr      = attr_q;
  assign done_key_valid = keyv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_L1;
      vlo_q     <= '0;
      instr_q   <= 1'b0;
      rd_addr_q <= '0;
      kidx_q    <= '0;
      fault_q   <= 1'b0;
      ppn_q     <= '0;
      attr_q    <= '0;
      keyv_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          vlo_q     <= req_vpn[LO_W-1:0];
          instr_q   <= req_is_instr;
          rd_addr_q <= slot_addr(root_ptr, AW'(req_vpn[VPN_W-1 -: L1_BITS]));
          phase_q   <= PH_L1;
          kidx_q    <= '0;
          fault_q   <= 1'b0;
          ppn_q     <= '0;
          attr_q    <= '0;
          keyv_q    <= 1'b0;
          state_q   <= ST_ISSUE;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          unique case (phase_q)
            PH_L1: begin
              if (ent_kind == ENT_TABLE) begin
                rd_addr_q <= slot_addr(ent_ptr, AW'(idx2));
                phase_q   <= PH_L2;
                state_q   <= ST_ISSUE;
              end else begin
                fault_q <= 1'b1;
                state_q <= ST_DONE;
              end
            end
            PH_L2: begin
              if (ent_kind == ENT_TABLE) begin
                rd_addr_q <= slot_addr(ent_ptr, AW'(idx3));
                phase_q   <= PH_L3;
                state_q   <= ST_ISSUE;
              end else if (ent_kind == ENT_KEYED) begin
                rd_addr_q <= ent_ptr;
                phase_q   <= PH_XLAT;
                state_q   <= ST_ISSUE;
              end else begin
                fault_q <= 1'b1;
                state_q <= ST_DONE;
              end
            end
            PH_L3: begin
              if (ent_kind == ENT_LEAF) begin
                ppn_q  <= ent_ppn;
                attr_q <= ent_attr;
              end else begin
                fault_q <= 1'b1;
              end
              state_q <= ST_DONE;
            end
            PH_XLAT: begin
              if (ent_kind == ENT_LEAF) begin
                ppn_q  <= ent_ppn;
                attr_q <= ent_attr;
                if (instr_q) begin
                  rd_addr_q <= next_word(rd_addr_q);
                  kidx_q    <= '0;
                  phase_q   <= PH_KEY;
                  state_q   <= ST_ISSUE;
                end else begin
                  state_q <= ST_DONE;
                end
              end else begin
                fault_q <= 1'b1;
                state_q <= ST_DONE;
              end
            end
            PH_KEY: begin
              if (kidx_q == KIW'(KEY_WORDS - 1)) begin
                keyv_q  <= 1'b1;
                state_q <= ST_DONE;
              end else begin
                kidx_q    <= kidx_q + KIW'(1);
                rd_addr_q <= next_word(rd_addr_q);
                state_q   <= ST_ISSUE;
              end
            end
            default: begin
              fault_q <= 1'b1;
              state_q <= ST_DONE;
            end
          endcase
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             outst_q <= 1'b0;
    else if (mem_rd_valid)  outst_q <= 1'b1;
    else if (mem_rsp_valid) outst_q <= 1'b0;
  end

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !outst_q); // R8

  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |=> !mem_rd_valid); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R9

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R9

  AST_SIDE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (done_is_instr == $past(req_is_instr))); // R9

endmodule

// File: rtl/kpt_walker.sv
module kpt_walker
  import kpt_pkg::*;
#(
  parameter int AW        = 32,
  parameter int L1_BITS   = 8,
  parameter int L2_BITS   = 6,
  parameter int L3_BITS   = 6,
  parameter int KEY_WORDS = 4,
  localparam int PG_BITS  = AW - L1_BITS - L2_BITS - L3_BITS,
  localparam int VPN_W    = AW - PG_BITS,
  localparam int ATTR_W   = PG_BITS - 2,
  localparam int KEY_W    = AW * KEY_WORDS,
  localparam int KIW      = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic              req_is_instr,
  input  logic [AW-1:0]     root_ptr,
  output logic              mem_rd_valid,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [AW-1:0]     mem_rsp_data,
  output logic              done_valid,
  output logic              done_fault,
  output logic              done_is_instr,
  output logic [VPN_W-1:0]  done_ppn,
  output logic [ATTR_W-1:0] done_attr,
  output logic              done_key_valid,
  output logic [KEY_W-1:0]  done_key
);

  ent_kind_e          ent_kind;
  logic [AW-1:0]      ent_ptr;
  logic [VPN_W-1:0]   ent_ppn;
  logic [ATTR_W-1:0]  ent_attr;
  logic               key_clr;
  logic               key_wr;
  logic [KIW-1:0]     key_idx;

  kpt_entry_decode #(.AW(AW), .PG_BITS(PG_BITS)) i_decode (
    .word (mem_rsp_data),
    .kind (ent_kind),
    .ptr  (ent_ptr),
    .ppn  (ent_ppn),
    .attr (ent_attr)
  );

  kpt_walk_ctrl #(
    .AW(AW), .L1_BITS(L1_BITS), .L2_BITS(L2_BITS), .L3_BITS(L3_BITS),
    .KEY_WORDS(KEY_WORDS)
  ) i_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_vpn        (req_vpn),
    .req_is_instr   (req_is_instr),
    .root_ptr       (root_ptr),
    .mem_rd_valid   (mem_rd_valid),
    .mem_rd_addr    (mem_rd_addr),
    .mem_rsp_valid  (mem_rsp_valid),
    .ent_kind       (ent_kind),
    .ent_ptr        (ent_ptr),
    .ent_ppn        (ent_ppn),
    .ent_attr       (ent_attr),
    .key_clr        (key_clr),
    .key_wr         (key_wr),
    .key_idx        (key_idx),
    .done_valid     (done_valid),
    .done_fault     (done_fault),
    .done_is_instr  (done_is_instr),
    .done_ppn       (done_ppn),
    .done_attr      (done_attr),
    .done_key_valid (done_key_valid)
  );

  kpt_key_collect #(.AW(AW), .KEY_WORDS(KEY_WORDS)) i_key (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (key_clr),
    .wr    (key_wr),
    .idx   (key_idx),
    .wdata (mem_rsp_data),
    .key   (done_key)
  );

  AST_KEY_INSTR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_key_valid) |-> done_is_instr); // R6

  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_fault) |-> (!done_key_valid && done_ppn == '0 && done_attr == '0)); // R9

  AST_NO_KEY_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_key_valid) |-> (done_key == '0)); // R6

endmodule

// File: tb/test_kpt_walker.sv
`timescale 1ns/1ps
module test_kpt_walker;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [19:0]  req_vpn = '0;
  logic         req_is_instr = 1'b0;
  logic [31:0]  root_ptr = 32'h0;
  logic         mem_rd_valid;
  logic [31:0]  mem_rd_addr;
  logic         mem_rsp_valid;
  logic [31:0]  mem_rsp_data;
  logic         done_valid;
  logic         done_fault;
  logic         done_is_instr;
  logic [19:0]  done_ppn;
  logic [9:0]   done_attr;
  logic         done_key_valid;
  logic [127:0] done_key;

  always #10 clk = ~clk;

  kpt_walker i_kpt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_is_instr(req_is_instr), .root_ptr(root_ptr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_valid(done_valid), .done_fault(done_fault), .done_is_instr(done_is_instr),
    .done_ppn(done_ppn), .done_attr(done_attr), .done_key_valid(done_key_valid),
    .done_key(done_key)
  );

  int n_checks = 0;
  int n_fail = 0;

  logic [31:0] mem [0:4095];
  int          lat = 0;
  int          nreads = 0;
  int          viol = 0;
  logic [31:0] rd_log [0:15];
  logic        pend = 1'b0;
  int          cnt = 0;
  logic [31:0] paddr = '0;
  logic        rsp_v = 1'b0;
  logic [31:0] rsp_d = '0;

  assign mem_rsp_valid = rsp_v;
  assign mem_rsp_data  = rsp_d;

  always @(posedge clk) begin
    rsp_v <= 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        rsp_v <= 1'b1;
        rsp_d <= mem[paddr[13:2]];
        pend  <= 1'b0;
      end else begin
        cnt <= cnt - 1;
      end
    end
    if (rst_n && mem_rd_valid) begin
      if (pend || rsp_v) viol <= viol + 1;
      pend  <= 1'b1;
      cnt   <= lat;
      paddr <= mem_rd_addr;
      if (nreads < 16) rd_log[nreads] <= mem_rd_addr;
      nreads <= nreads + 1;
    end
  end

  function automatic logic [31:0] e_table(input logic [31:0] base);
    return {base[31:2], 2'd1};
  endfunction
  function automatic logic [31:0] e_leaf(input logic [19:0] ppn, input logic [9:0] attr);
    return {ppn, attr, 2'd2};
  endfunction
  function automatic logic [31:0] e_keyed(input logic [31:0] p);
    return {p[31:2], 2'd3};
  endfunction
  function automatic logic [19:0] vpn_of(input logic [7:0] a, input logic [5:0] b,
                                         input logic [5:0] c);
    return {a, b, c};
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic         r_fault, r_instr, r_keyv;
  logic [19:0]  r_ppn;
  logic [9:0]   r_attr;
  logic [127:0] r_key;

  task automatic run_walk(input logic [19:0] vpn, input logic instr, input int latency);
    int guard;
    lat = latency;
    @(negedge clk);
    nreads = 0;
    guard = 0;
    while (!req_ready && guard < 2000) begin @(negedge clk); guard++; end
    req_valid = 1'b1; req_vpn = vpn; req_is_instr = instr;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 busy after accept", 128'(req_ready), 128'(0));
    guard = 0;
    while (!done_valid && guard < 2000) begin @(negedge clk); guard++; end
    if (guard >= 2000) check("R9 walk finished", 128'(0), 128'(1));
    r_fault = done_fault; r_instr = done_is_instr; r_keyv = done_key_valid;
    r_ppn = done_ppn; r_attr = done_attr; r_key = done_key;
    check("R9 side echoed", 128'(r_instr), 128'(instr));
    @(negedge clk);
    check("R9 done single pulse", 128'(done_valid), 128'(0));
  endtask

  task automatic expect_ok(input string tag, input logic [19:0] ppn, input logic [9:0] attr,
                           input logic keyv, input logic [127:0] key, input int reads);
    check({tag, " fault"}, 128'(r_fault), 128'(0));
    check({tag, " ppn"},   128'(r_ppn),   128'(ppn));
    check({tag, " attr"},  128'(r_attr),  128'(attr));
    check({tag, " keyv"},  128'(r_keyv),  128'(keyv));
    check({tag, " key"},   r_key,         key);
    check({tag, " reads"}, 128'(nreads),  128'(reads));
  endtask

  task automatic expect_fault(input string tag, input int reads);
    check({tag, " fault"},     128'(r_fault), 128'(1));
    check({tag, " reads"},     128'(nreads),  128'(reads));
    check({tag, " R9 ppn0"},   128'(r_ppn),   128'(0));
    check({tag, " R9 keyv0"},  128'(r_keyv),  128'(0));
  endtask

  localparam logic [127:0] KEY_A = {32'hD4D3D2D1, 32'hC4C3C2C1, 32'hB4B3B2B1, 32'hA4A3A2A1};

  task automatic t_reset();
    check("R1 ready", 128'(req_ready), 128'(1));
    check("R1 done", 128'(done_valid), 128'(0));
    check("R1 rd", 128'(mem_rd_valid), 128'(0));
  endtask

  task automatic t_plain();
    run_walk(vpn_of(8'h05, 6'h03, 6'h11), 1'b1, 0);
    expect_ok("R2 plain instr", 20'hABCDE, 10'h155, 1'b0, '0, 3);
    check("R2 L1 addr", 128'(rd_log[0]), 128'(32'h14));
    check("R2 L2 addr", 128'(rd_log[1]), 128'(32'h40C));
    check("R2 L3 addr", 128'(rd_log[2]), 128'(32'h844));
    run_walk(vpn_of(8'h05, 6'h03, 6'h11), 1'b0, 2);
    expect_ok("R2 plain data", 20'hABCDE, 10'h155, 1'b0, '0, 3);
  endtask

  task automatic t_keyed_instr();
    run_walk(vpn_of(8'h05, 6'h07, 6'h2A), 1'b1, 1);
    expect_ok("R5 keyed instr", 20'h12345, 10'h0AA, 1'b1, KEY_A, 7);
    check("R4 redirect addr", 128'(rd_log[2]), 128'(32'hC04));
    check("R5 key word0 addr", 128'(rd_log[3]), 128'(32'hC08));
    check("R5 key word3 addr", 128'(rd_log[6]), 128'(32'hC14));
  endtask

  task automatic t_keyed_data();
    run_walk(vpn_of(8'h05, 6'h07, 6'h2A), 1'b0, 3);
    expect_ok("R6 keyed data", 20'h12345, 10'h0AA, 1'b0, '0, 3);
    check("R4 data redirect addr", 128'(rd_log[2]), 128'(32'hC04));
    run_walk(vpn_of(8'h05, 6'h07, 6'h2A), 1'b1, 0);
    run_walk(vpn_of(8'h05, 6'h03, 6'h11), 1'b1, 0);
    expect_ok("R6 plain after keyed", 20'hABCDE, 10'h155, 1'b0, '0, 3);
  endtask

  task automatic t_invalid();
    run_walk(vpn_of(8'h09, 6'h00, 6'h00), 1'b1, 0);
    expect_fault("R3 invalid L1", 1);
    run_walk(vpn_of(8'h05, 6'h03, 6'h12), 1'b0, 1);
    expect_fault("R3 invalid L3", 3);
    run_walk(vpn_of(8'h05, 6'h08, 6'h00), 1'b1, 2);
    expect_fault("R4 bad translation word", 3);
  endtask

  task automatic t_illegal();
    run_walk(vpn_of(8'h0A, 6'h00, 6'h00), 1'b1, 0);
    expect_fault("R7 keyed at L1", 1);
    run_walk(vpn_of(8'h05, 6'h03, 6'h13), 1'b1, 1);
    expect_fault("R7 keyed at L3", 3);
    run_walk(vpn_of(8'h05, 6'h03, 6'h14), 1'b0, 0);
    expect_fault("R7 table at L3", 3);
    run_walk(vpn_of(8'h0B, 6'h00, 6'h00), 1'b0, 0);
    expect_fault("R7 leaf at L1", 1);
    run_walk(vpn_of(8'h05, 6'h09, 6'h00), 1'b1, 0);
    expect_fault("R7 leaf at L2", 2);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem[32'h014 >> 2] = e_table(32'h400);
    mem[32'h028 >> 2] = e_keyed(32'hC04);
    mem[32'h02C >> 2] = e_leaf(20'h11111, 10'h001);
    mem[32'h40C >> 2] = e_table(32'h800);
    mem[32'h41C >> 2] = e_keyed(32'hC06);
    mem[32'h420 >> 2] = e_keyed(32'hD0C);
    mem[32'h424 >> 2] = e_leaf(20'h22222, 10'h002);
    mem[32'h844 >> 2] = e_leaf(20'hABCDE, 10'h155);
    mem[32'h84C >> 2] = e_keyed(32'hC04);
    mem[32'h850 >> 2] = e_table(32'h800);
    mem[32'hC04 >> 2] = e_leaf(20'h12345, 10'h0AA);
    mem[32'hC08 >> 2] = KEY_A[31:0];
    mem[32'hC0C >> 2] = KEY_A[63:32];
    mem[32'hC10 >> 2] = KEY_A[95:64];
    mem[32'hC14 >> 2] = KEY_A[127:96];
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_keyed_instr();
    t_keyed_data();
    t_invalid();
    t_illegal();
    check("R8 one read outstanding", 128'(viol), 128'(0));
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R9 watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule